// File: doc/BRIEF.md
# Late-Write Burst Synchronous SRAM

A synthesizable model of a single-port synchronous SRAM. Its bus can switch between reads and writes on consecutive clocks with no idle cycle in between. Every address and control input is taken on the rising clock edge. Write data, however, follows its address by one clock (flow-through timing) or by two clocks (pipelined timing). A read can therefore be issued in the cycle right after a write, while that write's data is still on the way. Arriving write data is parked in a holding register and committed to the array one clock later. Any read that overlaps a write which is still pending is served per byte lane from the holding register, or from the data bus itself.

Two static straps configure the block. The timing strap selects either a registered read path (pipelined) or a direct one (flow-through). The order strap selects how an advance input steps the low two address bits during a burst: a linear wrap or an XOR interleave. The data word is made of 9-bit byte lanes, and each lane has its own write enable. A cycle is selected only when all three chip enables are active. An asynchronous output enable and an asynchronous sleep input can both silence the read port at any time. Sleep also blocks new accesses.

Top module: `lw_burst_sram`

## Requirements
- R1: All inputs are sampled on the rising edge of `clk`. A cycle starts an access when `ce1_n`=0, `ce2`=1, `ce3_n`=0, `sleep`=0 and `adv`=0. `we_n`=0 makes it a write and `we_n`=1 makes it a read.
- R2: With `pipe_mode`=0, the read word and `rdata_en`=1 appear in the clock cycle after the address edge. With `pipe_mode`=1, they appear one cycle later than that.
- R3: Write data is taken from `wdata` on the first rising edge after the address edge when `pipe_mode`=0, and on the second when `pipe_mode`=1.
- R4: Reads and writes in any mix may be issued on consecutive cycles. A read returns the result of every write whose address cycle came before it, including writes whose data has not yet reached the array.
- R5: `bw_n[i]`=0 enables lane i, which is bits [9i+8:9i]. The lane enables are sampled together with each address or burst beat. Lanes that are not enabled keep their contents.
- R6: With `adv`=1 during an active burst, the next access has the same type and upper address bits, and its low two address bits are the offset for beat k (k=1,2,3, then wrapping). With `lin_order`=1 the offset is (start+k) mod 4. With `lin_order`=0 it is start XOR k. `adv`=1 with no active burst does nothing. A cycle that neither advances nor starts an access ends the burst.
- R7: If any chip enable is inactive, the cycle writes nothing and drives no read data.
- R8: `oe_n`=1 forces `rdata_en` to 0 at once, without waiting for a clock edge. It does not change the state of any access in flight.
- R9: While `sleep`=1, new accesses and burst beats are ignored and `rdata_en` is 0. Writes accepted earlier still take their data and commit.
- R10: After reset no access is pending, and `rdata_en` is 0.
- R11: `rdata` is all zeros whenever `rdata_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | Static strap: 1 pipelined, 0 flow-through |
| lin_order | input | 1 | Static strap: 1 linear burst, 0 interleaved |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | 0 write, 1 read |
| adv | input | 1 | Continue the current burst |
| addr | input | ADDR_W | Word address |
| bw_n | input | LANES | Per-lane write enables, active low |
| wdata | input | LANES*LANE_W | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep request |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_en | output | 1 | Read data is being driven |

## Verification
The bench goes after the read-after-write hazard, in every timing and order combination. It issues a read one and two cycles after a write to the same word, with random lane masks. A design that forwarded nothing, or forwarded whole words instead of lanes, would return stale bytes. It sweeps bursts from every start offset in both orders, so a wrong wrap or XOR step shows up as data from the wrong word. It also checks that a write issued just before sleep still lands, that sleep, a single inactive chip enable and a stray advance all leave memory untouched, and that raising the output enable mid-cycle blanks the port at once rather than at the next edge.

// File: rtl/lw_burst_sram.sv
module lw_burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pipe_mode,
  input  logic                    lin_order,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    we_n,
  input  logic                    adv,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        bw_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_en
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 2;

  logic [DW-1:0] mem [DEPTH];

  logic            b_act, b_wr;
  logic [HI_W-1:0] b_base;
  logic [1:0]      b_st, b_cnt;

  logic              s1_v, s1_wr, s2_v, s2_wr;
  logic [ADDR_W-1:0] s1_a, s2_a;
  logic [LANES-1:0]  s1_be, s2_be;

  logic              h_v;
  logic [ADDR_W-1:0] h_a;
  logic [LANES-1:0]  h_be;
  logic [DW-1:0]     h_d, q_reg;

  function automatic logic [DW-1:0] lane_mix(input logic [DW-1:0] old_w,
                                             input logic [DW-1:0] new_w,
                                             input logic [LANES-1:0] en);
    logic [DW-1:0] r;
    r = old_w;
    for (int i = 0; i < LANES; i++)
      if (en[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    return r;
  endfunction

  wire sel   = !ce1_n && ce2 && !ce3_n && !sleep;
  wire cont  = adv && b_act && !sleep;
  wire newop = sel && !adv;

  wire [1:0] nxt_cnt = b_cnt + 2'd1;
  wire [1:0] nxt_off = lin_order ? (b_st + nxt_cnt) : (b_st ^ nxt_cnt);

  wire              acc_v  = cont || newop;
  wire              acc_wr = cont ? b_wr : !we_n;
  wire [ADDR_W-1:0] acc_a  = cont ? {b_base, nxt_off} : addr;

  wire              w_v  = pipe_mode ? (s2_v && s2_wr) : (s1_v && s1_wr);
  wire [ADDR_W-1:0] w_a  = pipe_mode ? s2_a : s1_a;
  wire [LANES-1:0]  w_be = pipe_mode ? s2_be : s1_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_act <= 1'b0; b_wr <= 1'b0; b_base <= '0; b_st <= '0; b_cnt <= '0;
    end else if (cont) begin
      b_cnt <= nxt_cnt;
    end else if (newop) begin
      b_act  <= 1'b1;
      b_wr   <= !we_n;
      b_base <= addr[ADDR_W-1:2];
      b_st   <= addr[1:0];
      b_cnt  <= 2'd0;
    end else begin
      b_act <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_wr <= 1'b0; s1_a <= '0; s1_be <= '0;
      s2_v <= 1'b0; s2_wr <= 1'b0; s2_a <= '0; s2_be <= '0;
      h_v  <= 1'b0; h_a <= '0; h_be <= '0; h_d <= '0;
    end else begin
      s1_v  <= acc_v;
      s1_wr <= acc_wr;
      s1_a  <= acc_a;
      s1_be <= ~bw_n;
      s2_v  <= s1_v;
      s2_wr <= s1_wr;
      s2_a  <= s1_a;
      s2_be <= s1_be;
      h_v   <= w_v;
      h_a   <= w_a;
      h_be  <= w_be;
      h_d   <= wdata;
    end
  end

  always_ff @(posedge clk)
    if (h_v) mem[h_a] <= lane_mix(mem[h_a], h_d, h_be);

  wire [LANES-1:0] h_hit = (h_v && h_a == s1_a) ? h_be : '0;
  wire [LANES-1:0] d_hit = (pipe_mode && s2_v && s2_wr && s2_a == s1_a) ? s2_be : '0;
  wire [DW-1:0]    rd_mix = lane_mix(lane_mix(mem[s1_a], h_d, h_hit), wdata, d_hit);

  always_ff @(posedge clk) q_reg <= rd_mix;

  wire drv = pipe_mode ? (s2_v && !s2_wr) : (s1_v && !s1_wr);

  assign rdata_en = drv && !oe_n && !sleep;
  assign rdata    = rdata_en ? (pipe_mode ? q_reg : rd_mix) : '0;

  // R2
  rd_flow_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_v && !acc_wr && !pipe_mode) |=> drv);
  // R2
  rd_pipe_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_v && !acc_wr && pipe_mode) |=> ##1 drv);
  // R3
  wr_flow_arrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_v && acc_wr && !pipe_mode) |=> ##1 h_v);
  // R3
  wr_pipe_arrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_v && acc_wr && pipe_mode) |=> ##2 h_v);
  // R9
  sleep_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !s1_v);
  // R7
  desel_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && (ce1_n || !ce2 || ce3_n)) |=> !s1_v);
endmodule

// File: tb/lw_burst_sram_tb.sv
`timescale 1ns/1ps
module lw_burst_sram_tb;
  localparam int AW = 4, LN = 4, LW = 9, DW = LN*LW, DEP = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, pipe_mode, lin_order, ce1_n, ce2, ce3_n, we_n, adv, oe_n, sleep;
  logic [AW-1:0] addr;
  logic [LN-1:0] bw_n;
  logic [DW-1:0] wdata, rdata;
  logic rdata_en;

  lw_burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .lin_order(lin_order),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n), .adv(adv),
    .addr(addr), .bw_n(bw_n), .wdata(wdata), .oe_n(oe_n), .sleep(sleep),
    .rdata(rdata), .rdata_en(rdata_en));

  int total = 0, bad = 0, n = 0, wl = 1, rl = 0;
  string tag = "R10";
  logic [DW-1:0] refm [DEP];
  logic [DW-1:0] dsch [8];
  logic [DW-1:0] ed [8];
  logic ev [8];
  logic [15:0] lf = 16'hACE1;
  bit oe_rand = 0, oe_async = 0;
  bit bact = 0, bwr = 0;
  logic [AW-3:0] bbase;
  logic [1:0] bst, bcnt;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at n=%0d", req, act, exp, n);
    end
  endtask

  task automatic lfs();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  // kind: 0 deselect (write attempt), 1 read, 2 write, 3 advance, 4 sleep
  task automatic step(input int kind, input logic [AW-1:0] a, input logic [LN-1:0] be);
    logic [AW-1:0] ea;
    logic [DW-1:0] dat;
    bit exp_en, is_rd, is_wr;
    int s;
    @(negedge clk);
    s = (n - 1) & 7;
    exp_en = ev[s] && !sleep && !oe_n;
    chk(rdata_en == exp_en, tag, DW'(rdata_en), DW'(exp_en));
    if (exp_en) chk(rdata == ed[s], tag, rdata, ed[s]);
    else chk(rdata == '0, "R11", rdata, '0);
    if (oe_async && exp_en) begin
      oe_n = 1'b1;
      #0.5;
      chk(!rdata_en && rdata == '0, "R8", {rdata_en, rdata[DW-2:0]}, '0);
    end
    ev[s] = 1'b0;
    ce1_n = 0; ce2 = 1; ce3_n = 0; we_n = 1; adv = 0; sleep = 0; bw_n = '1; addr = a;
    lfs();
    oe_n = oe_rand ? lf[2] : 1'b0;
    wdata = dsch[n & 7];
    dsch[n & 7] = {DW{1'b1}} ^ DW'(n);
    is_rd = 0; is_wr = 0; ea = a;
    case (kind)
      1, 2: begin
        bact = 1; bwr = (kind == 2); bbase = a[AW-1:2]; bst = a[1:0]; bcnt = 0;
        we_n = (kind == 1); is_rd = (kind == 1); is_wr = (kind == 2);
      end
      3: begin
        adv = 1;
        if (bact) begin
          bcnt = bcnt + 2'd1;
          ea = {bbase, lin_order ? (bst + bcnt) : (bst ^ bcnt)};
          is_rd = !bwr; is_wr = bwr;
        end
      end
      4: begin sleep = 1; we_n = 0; adv = a[0]; bact = 0; end
      default: begin
        we_n = 0; bact = 0;
        case (a % 3)
          0: ce1_n = 1;
          1: ce2 = 0;
          default: ce3_n = 1;
        endcase
      end
    endcase
    if (is_wr) begin
      bw_n = ~be;
      dat = {4'(n), 32'(n * 32'h9E3779B1)};
      dsch[(n + wl) & 7] = dat;
      for (int i = 0; i < LN; i++)
        if (be[i]) refm[ea][i*LW +: LW] = dat[i*LW +: LW];
    end
    if (is_rd) begin
      ev[(n + rl) & 7] = 1'b1;
      ed[(n + rl) & 7] = refm[ea];
    end
    @(posedge clk);
    n++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ce1_n = 1; ce2 = 0; ce3_n = 1; we_n = 1; adv = 0; oe_n = 0; sleep = 0;
    bw_n = '1; addr = '0; wdata = '0; bact = 0;
    for (int i = 0; i < 8; i++) ev[i] = 1'b0;
    repeat (2) @(negedge clk);
    tag = "R10";
    chk(rdata_en == 1'b0, "R10", DW'(rdata_en), '0);
    chk(rdata == '0, "R10", rdata, '0);
    rst_n = 1;
    @(posedge clk);
    n++;
  endtask

  initial begin
    rst_n = 0; pipe_mode = 0; lin_order = 0;
    for (int c = 0; c < 4; c++) begin
      pipe_mode = c[0]; lin_order = c[1];
      wl = pipe_mode ? 2 : 1; rl = pipe_mode ? 1 : 0;
      do_reset();
      tag = "R3";
      for (int a = 0; a < DEP; a++) step(2, AW'(a), '1);
      tag = "R2";
      for (int a = 0; a < DEP; a++) step(1, AW'(a), '0);
      tag = "R4";
      for (int i = 0; i < 48; i++) begin
        lfs();
        step(2, AW'(i), lf[3:0]);
        step(1, AW'(i), '0);
        step(2, AW'(i + 1), lf[7:4]);
        step(2, AW'(i), lf[11:8]);
        step(1, AW'(i), '0);
        step(1, AW'(i + 1), '0);
      end
      tag = "R1";
      for (int i = 0; i < 200; i++) begin
        lfs();
        step(lf[15:13] > 4 ? 1 + lf[0] : int'(lf[15:13]), lf[AW-1:0], lf[11:8]);
      end
      tag = "R6";
      for (int st = 0; st < 4; st++)
        for (int k = 1; k < 3; k++) begin
          lfs();
          step(k, {2'b01, 2'(st)}, lf[3:0] | 4'b0001);
          repeat (3) step(3, '0, lf[7:4]);
          step(1, {2'b01, 2'(st)}, '0);
          repeat (4) step(3, '0, '0);
        end
      step(0, '0, '0);
      step(3, 4'h5, '1);
      step(1, 4'h5, '0);
      tag = "R5";
      for (int b = 0; b < 16; b++) begin
        step(2, 4'h9, 4'(b));
        step(1, 4'h9, '0);
      end
      tag = "R7";
      for (int v = 0; v < 3; v++) begin
        step(0, AW'(v), '1);
        step(1, AW'(v), '0);
        step(1, AW'(v), '0);
      end
      tag = "R9";
      for (int i = 0; i < 4; i++) begin
        step(2, AW'(i + 4), '1);
        step(4, AW'(i), '1);
        step(4, AW'(i + 4), '1);
        step(1, AW'(i + 4), '0);
        step(1, AW'(i), '0);
        step(4, '0, '0);
        step(1, AW'(i + 4), '0);
        step(1, AW'(i), '0);
      end
      tag = "R8";
      oe_rand = 1;
      for (int i = 0; i < 40; i++) step(1, AW'(i), '0);
      oe_rand = 0; oe_async = 1;
      for (int i = 0; i < 10; i++) step(1, AW'(i), '0);
      oe_async = 0;
      repeat (4) step(0, '0, '0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish, act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule